// File: doc/BRIEF.md
# NAND Flash Cycle Sequencer

This block turns a single start request into one complete NAND flash access on an 8-bit shared bus. A configuration register chooses how many command phases are issued, how many address bytes follow, whether a data phase is included, and whether the large-device interpretation of the address-byte code applies. The same register holds the two command opcodes. On start, the block takes a snapshot of the configuration, the target address, the write byte and the transfer direction. It then walks through the phases one at a time and drives the command-latch, address-latch, write-enable and read-enable strobes.

Each phase takes two clock cycles. In the first cycle the strobe is low. In the second cycle it is high, while the bus byte and the latch signals stay steady. A device wait input, held low, holds the start of a phase. After the last phase a one-cycle done pulse is raised. For a read, the byte sampled from the bus is then on `rdata`.

Top module: `nand_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 22'h110000 (address code 01, data-phase bit set, every other field 0). `busy` and `done` are 0, `cle` and `ale` are 0, and `we_n` and `re_n` are 1.
- R2: A `cfg_wr` pulse loads `cfg_wdata` into the configuration register, and `cfg_rdata` returns it. The fields are: bits 7:0 first opcode, bits 15:8 second opcode, bits 17:16 address code, bits 19:18 command count, bit 20 data-phase enable, bit 21 large-device mode.
- R3: Phases run in this order. First the first opcode, when the command count is not 0. Then the address bytes, least significant byte first (byte j is addr[8j+7:8j]). Then the data phase, when bit 20 is set. Last the second opcode, when bit 19 is set (count 2 or 3).
- R4: With bit 21 clear, address code 0 gives one address byte, and codes 1 to 3 give that many bytes.
- R5: With bit 21 set, the number of address bytes is the code plus one: code 3 gives four, code 2 gives three, code 1 gives two and code 0 gives one.
- R6: Every phase lasts two cycles. The strobe is low in the first cycle and high in the second. `cle` is 1 during both cycles of a command phase, and `ale` is 1 during both cycles of an address phase. During command, address and write-data phases, `io_oe` is 1 and `io_out` carries the phase byte.
- R7: A data phase with `rd_dir`=0 drives the snapshot write byte and pulses `we_n`. With `rd_dir`=1 it pulses `re_n` instead, holds `io_oe` at 0, and captures `io_in` at the clock edge that ends the low cycle into `rdata`.
- R8: With bit 20 clear, no data phase runs: neither strobe pulses between the address phases and the second command.
- R9: `busy` is 1 from the cycle after start was accepted through the high cycle of the last phase. `done` is 1 for exactly the next cycle, with `busy` 0.
- R10: While `busy` is 1, `start` is ignored. No new sequence follows, and the running one keeps its snapshot even if `addr` and `wdata` change.
- R11: While `nand_rdy` is 0 at the first cycle of a phase, that phase is held with both strobes high, and it resumes when `nand_rdy` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 22 | Configuration write value |
| cfg_rdata | output | 22 | Current configuration |
| start | input | 1 | Begin an access (taken when idle) |
| addr | input | ADDR_W | Target address, bytes sent LSB first |
| wdata | input | BUS_W | Byte for a write data phase |
| rd_dir | input | 1 | 1 = data phase reads, 0 = writes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | BUS_W | Byte captured by the last read phase |
| io_out | output | BUS_W | Bus byte driven to the device |
| io_oe | output | 1 | Bus output enable |
| io_in | input | BUS_W | Bus byte from the device |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable, active low |
| nand_rdy | input | 1 | Device ready; low holds the next phase |

## Verification
The bench builds the block with its defaults: a 32-bit address, an 8-bit bus and a ready input used without synchronizer stages. With no synchronizer, a change on the ready pin shows up in the strobes in the same cycle. The bench sweeps all 64 values of the six control bits in both transfer directions, so every combination of command count, address code, size mode and data-phase enable runs once with varied address bytes. During each run it changes the address and write inputs, and raises start again, which checks that the snapshot is kept. Some runs hold the ready input low at the first phase.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   localparam int CFG_W      = 22;
   localparam int OP_W       = 8;
   localparam int MAX_ABYTES = 4;

   typedef enum logic [1:0] {
      PH_CMD_A = 2'd0,
      PH_ADDR  = 2'd1,
      PH_DATA  = 2'd2,
      PH_CMD_B = 2'd3
   } phase_e;

   typedef struct packed {
      logic            big_dev;
      logic            data_en;
      logic [1:0]      cmd_cnt;
      logic [1:0]      addr_code;
      logic [OP_W-1:0] op_b;
      logic [OP_W-1:0] op_a;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{
      big_dev:   1'b0,
      data_en:   1'b1,
      cmd_cnt:   2'd0,
      addr_code: 2'd1,
      op_b:      8'h00,
      op_a:      8'h00
   };

   // Number of address bytes selected by the code and the size mode.
   function automatic logic [2:0] addr_bytes(input logic big, input logic [1:0] code);
      if (big)
         return {1'b0, code} + 3'd1;
      else if (code == 2'd0)
         return 3'd1;
      else
         return {1'b0, code};
   endfunction

endpackage

// File: rtl/nand_seq_cfg.sv
module nand_seq_cfg
   import nand_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg_o
);

   cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= CFG_RESET;
      else if (wr)
         cfg_q <= cfg_t'(wdata);
   end

   assign cfg_o = cfg_q;

endmodule

// File: rtl/nand_seq_plan.sv
module nand_seq_plan
   import nand_seq_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int AB_W  = 2
) (
   input  cfg_t             cfg,
   input  logic [IDX_W-1:0] idx,
   output phase_e           kind,
   output logic [AB_W-1:0]  byte_sel,
   output logic [IDX_W-1:0] last_idx
);

   logic             has_a;
   logic             has_b;
   logic [2:0]       n_ab;
   logic [IDX_W-1:0] n_ab_x;
   logic [IDX_W-1:0] rel;

   assign has_a  = |cfg.cmd_cnt;
   assign has_b  = cfg.cmd_cnt[1];
   assign n_ab   = addr_bytes(cfg.big_dev, cfg.addr_code);
   assign n_ab_x = IDX_W'(n_ab);
   assign rel    = idx - IDX_W'(has_a);

   assign last_idx = IDX_W'(has_a) + n_ab_x + IDX_W'(cfg.data_en)
                   + IDX_W'(has_b) - IDX_W'(1);

   always_comb begin
      byte_sel = rel[AB_W-1:0];
      if (has_a && idx == '0)
         kind = PH_CMD_A;
      else if (rel < n_ab_x)
         kind = PH_ADDR;
      else if (cfg.data_en && rel == n_ab_x)
         kind = PH_DATA;
      else
         kind = PH_CMD_B;
   end

endmodule

// File: rtl/nand_seq_abyte.sv
module nand_seq_abyte #(
   parameter int ADDR_W = 32,
   parameter int BUS_W  = 8,
   parameter int NBYTES = 4,
   parameter int SEL_W  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEL_W-1:0]  sel,
   output logic [BUS_W-1:0]  byte_o
);

   logic [BUS_W-1:0] lanes [NBYTES];

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      assign lanes[g] = addr[g*BUS_W +: BUS_W];
   end

   assign byte_o = lanes[sel];

endmodule

// File: rtl/nand_seq.sv
module nand_seq
   import nand_seq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BUS_W      = 8,
   parameter int RDY_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              rd_dir,
   output logic              busy,
   output logic              done,
   output logic [BUS_W-1:0]  rdata,
   output logic [BUS_W-1:0]  io_out,
   output logic              io_oe,
   input  logic [BUS_W-1:0]  io_in,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   input  logic              nand_rdy
);

   localparam int MAX_PH = 2 + MAX_ABYTES + 1;
   localparam int IDX_W  = $clog2(MAX_PH);
   localparam int AB_W   = $clog2(MAX_ABYTES);

   if (BUS_W != OP_W) begin : g_bad_bus
      $error("nand_seq: BUS_W must equal the opcode width");
   end
   if (ADDR_W < BUS_W * MAX_ABYTES) begin : g_bad_addr
      $error("nand_seq: ADDR_W too narrow for the largest address phase count");
   end
   if (RDY_STAGES < 0) begin : g_bad_sync
      $error("nand_seq: RDY_STAGES must not be negative");
   end

   // ready input, optionally synchronised
   logic rdy_s;
   if (RDY_STAGES == 0) begin : g_rdy_direct
      assign rdy_s = nand_rdy;
   end else begin : g_rdy_sync
      logic [RDY_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sync_q <= '0;
         else
            sync_q <= {sync_q[RDY_STAGES-2 >= 0 ? RDY_STAGES-2 : 0 : 0], nand_rdy} ;
      end
      assign rdy_s = sync_q[RDY_STAGES-1];
   end

   cfg_t cfg_cur;

   nand_seq_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .cfg_o (cfg_cur)
   );

   assign cfg_rdata = cfg_cur;

   // sequencing state
   logic              busy_q;
   logic              half_q;
   logic [IDX_W-1:0]  idx_q;
   cfg_t              snap_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BUS_W-1:0]  wdata_q;
   logic              dir_q;
   logic              done_q;
   logic [BUS_W-1:0]  rdata_q;

   phase_e            kind;
   logic [AB_W-1:0]   byte_sel;
   logic [IDX_W-1:0]  last_idx;
   logic [BUS_W-1:0]  abyte;

   nand_seq_plan #(
      .IDX_W (IDX_W),
      .AB_W  (AB_W)
   ) u_plan (
      .cfg      (snap_q),
      .idx      (idx_q),
      .kind     (kind),
      .byte_sel (byte_sel),
      .last_idx (last_idx)
   );

   nand_seq_abyte #(
      .ADDR_W (ADDR_W),
      .BUS_W  (BUS_W),
      .NBYTES (MAX_ABYTES),
      .SEL_W  (AB_W)
   ) u_abyte (
      .addr   (addr_q),
      .sel    (byte_sel),
      .byte_o (abyte)
   );

   logic rd_ph;
   logic go;
   logic [BUS_W-1:0] bus_byte;

   assign rd_ph = busy_q && kind == PH_DATA && dir_q;
   assign go    = busy_q && !half_q && rdy_s;

   always_comb begin
      case (kind)
         PH_CMD_A: bus_byte = snap_q.op_a;
         PH_CMD_B: bus_byte = snap_q.op_b;
         PH_ADDR:  bus_byte = abyte;
         default:  bus_byte = wdata_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         half_q  <= 1'b0;
         idx_q   <= '0;
         snap_q  <= CFG_RESET;
         addr_q  <= '0;
         wdata_q <= '0;
         dir_q   <= 1'b0;
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else if (!busy_q) begin
         done_q <= 1'b0;
         if (start) begin
            busy_q  <= 1'b1;
            half_q  <= 1'b0;
            idx_q   <= '0;
            snap_q  <= cfg_cur;
            addr_q  <= addr;
            wdata_q <= wdata;
            dir_q   <= rd_dir;
         end
      end else begin
         done_q <= 1'b0;
         if (!half_q) begin
            if (rdy_s) begin
               half_q <= 1'b1;
               if (rd_ph)
                  rdata_q <= io_in;
            end
         end else if (idx_q == last_idx) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            idx_q  <= idx_q + IDX_W'(1);
            half_q <= 1'b0;
         end
      end
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign rdata  = rdata_q;
   assign cle    = busy_q && (kind == PH_CMD_A || kind == PH_CMD_B);
   assign ale    = busy_q && kind == PH_ADDR;
   assign we_n   = !(go && !rd_ph);
   assign re_n   = !(go && rd_ph);
   assign io_oe  = busy_q && !rd_ph;
   assign io_out = busy_q ? bus_byte : '0;

   // ---------------- assertions ----------------
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (we_n && re_n && !cle && !ale));

   p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));

   p_we_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> we_n);

   p_re_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |=> re_n);

   p_read_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !io_oe);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(addr_q) && $stable(snap_q) && $stable(wdata_q)));

   p_hold_on_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !half_q && !rdy_s) |=> ($stable(idx_q) && busy));

endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [21:0] cfg_wdata = '0;
   logic [21:0] cfg_rdata;
   logic        start = 1'b0;
   logic [31:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        rd_dir = 1'b0;
   logic        busy, done;
   logic [7:0]  rdata, io_out;
   logic        io_oe;
   logic [7:0]  io_in = '0;
   logic        cle, ale, we_n, re_n;
   logic        nand_rdy = 1'b1;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_seq u_nand_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .start(start), .addr(addr), .wdata(wdata), .rd_dir(rd_dir),
      .busy(busy), .done(done), .rdata(rdata),
      .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
      .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
      .nand_rdy(nand_rdy)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_seq(input logic [21:0] c, input logic [31:0] a,
                          input logic [7:0] wd, input bit rd, input int hold);
      int          kinds [8];
      logic [7:0]  bytes [8];
      int          n;
      int          na;
      logic [7:0]  rb;
      bit          rdk;
      n  = 0;
      na = c[21] ? int'(c[17:16]) + 1 : (c[17:16] == 2'd0 ? 1 : int'(c[17:16]));
      rb = a[15:8] ^ 8'hC3;
      if (c[19:18] != 2'd0) begin kinds[n] = 0; bytes[n] = c[7:0]; n++; end
      for (int j = 0; j < na; j++) begin kinds[n] = 1; bytes[n] = a[8*j +: 8]; n++; end
      if (c[20]) begin kinds[n] = 2; bytes[n] = rd ? rb : wd; n++; end
      if (c[19]) begin kinds[n] = 3; bytes[n] = c[15:8]; n++; end

      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = c;
      @(negedge clk); cfg_wr = 1'b0;
      #1 check(cfg_rdata == c, "R2 cfg readback", 32'(cfg_rdata), 32'(c));
      start = 1'b1; addr = a; wdata = wd; rd_dir = rd; nand_rdy = (hold == 0);

      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (k == 0) begin
            addr = ~a; wdata = ~wd;
            for (int h = 0; h < hold; h++) begin
               #1 check(we_n && re_n && busy, "R11 hold while not ready",
                        {29'd0, we_n, re_n, busy}, 32'h7);
               @(negedge clk);
            end
            nand_rdy = 1'b1;
         end
         rdk   = (kinds[k] == 2) && rd;
         io_in = rdk ? rb : 8'h00;
         #1;
         check(cle == (kinds[k] == 0 || kinds[k] == 3) && ale == (kinds[k] == 1),
               "R6 latch signals", {30'd0, cle, ale},
               {30'd0, 1'(kinds[k] == 0 || kinds[k] == 3), 1'(kinds[k] == 1)});
         check(we_n == rdk && re_n == !rdk && io_oe == !rdk,
               rdk ? "R7 read strobe" : "R6 write strobe",
               {29'd0, we_n, re_n, io_oe}, {29'd0, rdk, !rdk, !rdk});
         if (!rdk)
            check(io_out == bytes[k],
                  kinds[k] == 1 ? (c[21] ? "R5 address byte" : "R4 address byte")
                                : (kinds[k] == 2 ? "R7 write byte" : "R3 opcode byte"),
                  32'(io_out), 32'(bytes[k]));
         if (!c[20])
            check(kinds[k] != 2, "R8 no data phase", kinds[k], 0);
         @(negedge clk);
         if (k == 0) begin start = 1'b1; addr = 32'hDEADBEEF; end
         #1 check(we_n && re_n && busy && cle == (kinds[k] == 0 || kinds[k] == 3)
                  && ale == (kinds[k] == 1),
                  "R6 high half", {28'd0, we_n, re_n, cle, ale}, {28'd0, 2'b11,
                  1'(kinds[k] == 0 || kinds[k] == 3), 1'(kinds[k] == 1)});
      end
      @(negedge clk); start = 1'b0;
      #1 check(done && !busy, c[20] ? "R9 done pulse" : "R8 R9 done without data",
               {30'd0, done, busy}, 32'h2);
      if (rd && c[20])
         check(rdata == rb, "R7 captured read byte", 32'(rdata), 32'(rb));
      @(negedge clk);
      #1 check(!done && !busy, "R10 start during busy ignored",
               {30'd0, done, busy}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(cfg_rdata == 22'h110000, "R1 reset config", 32'(cfg_rdata), 32'h110000);
      check(!busy && !done, "R1 reset status", {30'd0, busy, done}, 0);
      check(we_n && re_n && !cle && !ale, "R1 reset strobes",
            {28'd0, we_n, re_n, cle, ale}, 32'hC);
      for (int i = 0; i < 64; i++) begin
         for (int r = 0; r < 2; r++) begin
            logic [31:0] a;
            logic [21:0] c;
            a = {8'(i + 4), 8'(i + 3), 8'(i + 2), 8'(i + 1)} ^ 32'h5A3C9612;
            c = {6'(i), 8'(8'h30 + i), 8'(8'h80 + i)};
            run_seq(c, a, 8'(8'hE0 ^ i), r[0], (i % 5 == 0) ? 2 + r : 0);
         end
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule